// File: doc/BRIEF.md
# SPI/GPIO Shared Port Pin Multiplexer

This block sits between an eight-pin port and three users: two SPI engines and a set of general-purpose I/O registers. A select register holds one bit per pin. A set bit gives the pin to the SPI engine that owns its group. A clear bit leaves the pin under GPIO control. The GPIO side has a direction register and an output data register. The block drives the pad output enables and output values, and it routes pad samples to the SPI engines and to the GPIO read path.

Pins 0 to 3 form the group of the first SPI engine and pins 4 to 7 the group of the second. Inside each group, the lowest pin is MISO, the next is MOSI, then SCK, and the highest is the slave-select pin. Each engine reports whether it is a master. The block tells each engine whether its slave-select pin is wired in for mode-fault sensing. It also raises a per-engine flag when a slave engine does not own all four of its pins.

Top module: `spi_gpio_pinmux`

## Requirements
- R1: While rstN is low, the select, direction and data registers read back 0, every padOe bit is 0, and every pin is a GPIO input.
- R2: A write with busWrEn high to address 0 (select), 1 (direction) or 2 (data) loads busWrData at the next rising clock edge. busRdData returns the addressed register combinationally. Address 3 reads as 0, and a write to address 3 changes no register.
- R3: For a pin whose select bit is 0, padOe equals its direction bit and padOut equals its data bit.
- R4: For a pin whose select bit is 1, the direction bit is ignored. MOSI and SCK are driven (padOe=1) when that engine's spiMaster is 1. MISO is driven when spiMaster is 0. The slave-select pin is never driven.
- R5: A driven SPI-owned pin outputs the engine's value for that role: spiMisoOut, spiMosiOut or spiSckOut. An undriven SPI-owned pin has padOut 0.
- R6: spiMisoIn, spiMosiIn and spiSckIn of an engine carry the pad level of the matching pin while that pin is SPI-owned, and 0 otherwise. spiSsIn carries the pad level while the slave-select pin is SPI-owned, and 1 (inactive) otherwise.
- R7: A read of address 2 returns, per pin, the latched data bit when the pin is a GPIO output (select 0, direction 1), and the pad level in every other case.
- R8: ssValid[g] equals the select bit of that engine's slave-select pin: bit 3 for engine 0 and bit 7 for engine 1.
- R9: cfgError[g] is 1 exactly when spiMaster[g] is 0 and any of the four select bits of group g is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address: 0 select, 1 direction, 2 data |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr |
| padIn | input | 8 | Sampled pad levels |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| spiMaster | input | 2 | Per-engine role, 1 = master |
| spiMisoOut | input | 2 | MISO value from each engine |
| spiMosiOut | input | 2 | MOSI value from each engine |
| spiSckOut | input | 2 | SCK value from each engine |
| spiMisoIn | output | 2 | MISO pad level to each engine |
| spiMosiIn | output | 2 | MOSI pad level to each engine |
| spiSckIn | output | 2 | SCK pad level to each engine |
| spiSsIn | output | 2 | Slave-select pad level to each engine, 1 when not owned |
| ssValid | output | 2 | Slave-select pin is wired to the engine |
| cfgError | output | 2 | Slave engine lacks one of its pins |

## Verification
The assertions assume that rstN starts low and that the bus and role inputs carry known levels on every rising edge. The properties are written as implications over the current select bits and roles, so they do not depend on any ordering between writes and role changes. The stimulus drives every input away from the clock edge with defined values. It keeps busAddr inside its two-bit range, includes address 3 on purpose, and changes spiMaster freely, so that every select and role combination appears, including the slave cases that are not allowed.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  typedef enum logic [1:0] {
    REG_SEL  = 2'd0,
    REG_DIR  = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic selWr;
    logic dirWr;
    logic dataWr;
  } regStb_t;

  localparam int GROUP_W  = 4;
  localparam int ROLE_MISO = 0;
  localparam int ROLE_MOSI = 1;
  localparam int ROLE_SCK  = 2;
  localparam int ROLE_SS   = 3;
endpackage

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
#(
  parameter int NUM_SPI = 2,
  localparam int PINS = NUM_SPI * GROUP_W
) (
  input  logic [1:0]         busAddr,
  input  logic               busWrEn,
  input  logic [PINS-1:0]    selQ,
  input  logic [NUM_SPI-1:0] spiMaster,
  output regStb_t            stb,
  output regSel_e            rdSel,
  output logic [NUM_SPI-1:0] ssValid,
  output logic [NUM_SPI-1:0] cfgError
);
  always_comb begin
    rdSel = regSel_e'(busAddr);
    stb   = '0;
    if (busWrEn) begin
      unique case (rdSel)
        REG_SEL:  stb.selWr  = 1'b1;
        REG_DIR:  stb.dirWr  = 1'b1;
        REG_DATA: stb.dataWr = 1'b1;
        default:  stb        = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SPI; g++) begin : gGroup
    logic [GROUP_W-1:0] grpSel;
    assign grpSel      = selQ[g*GROUP_W +: GROUP_W];
    assign ssValid[g]  = grpSel[ROLE_SS];
    assign cfgError[g] = !spiMaster[g] && !(&grpSel);
  end
endmodule

// File: rtl/pinmux_datapath.sv
module pinmux_datapath
  import pinmux_pkg::*;
#(
  parameter int NUM_SPI = 2,
  localparam int PINS = NUM_SPI * GROUP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStb_t            stb,
  input  regSel_e            rdSel,
  input  logic [PINS-1:0]    busWrData,
  output logic [PINS-1:0]    busRdData,
  input  logic [PINS-1:0]    padIn,
  output logic [PINS-1:0]    padOut,
  output logic [PINS-1:0]    padOe,
  input  logic [NUM_SPI-1:0] spiMaster,
  input  logic [NUM_SPI-1:0] spiMisoOut,
  input  logic [NUM_SPI-1:0] spiMosiOut,
  input  logic [NUM_SPI-1:0] spiSckOut,
  output logic [NUM_SPI-1:0] spiMisoIn,
  output logic [NUM_SPI-1:0] spiMosiIn,
  output logic [NUM_SPI-1:0] spiSckIn,
  output logic [NUM_SPI-1:0] spiSsIn,
  output logic [PINS-1:0]    selQ,
  output logic [PINS-1:0]    dirQ
);
  logic [PINS-1:0] dataQ;
  logic [PINS-1:0] dataView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      dirQ  <= '0;
      dataQ <= '0;
    end else begin
      if (stb.selWr)  selQ  <= busWrData;
      if (stb.dirWr)  dirQ  <= busWrData;
      if (stb.dataWr) dataQ <= busWrData;
    end
  end

  for (genvar g = 0; g < NUM_SPI; g++) begin : gGroup
    localparam int BASE = g * GROUP_W;
    logic [GROUP_W-1:0] spiOe;
    logic [GROUP_W-1:0] spiVal;

    assign spiOe[ROLE_MISO]  = !spiMaster[g];
    assign spiOe[ROLE_MOSI]  = spiMaster[g];
    assign spiOe[ROLE_SCK]   = spiMaster[g];
    assign spiOe[ROLE_SS]    = 1'b0;
    assign spiVal[ROLE_MISO] = spiMisoOut[g];
    assign spiVal[ROLE_MOSI] = spiMosiOut[g];
    assign spiVal[ROLE_SCK]  = spiSckOut[g];
    assign spiVal[ROLE_SS]   = 1'b0;

    for (genvar r = 0; r < GROUP_W; r++) begin : gPin
      localparam int P = BASE + r;
      always_comb begin
        if (selQ[P]) begin
          padOe[P]  = spiOe[r];
          padOut[P] = spiOe[r] & spiVal[r];
        end else begin
          padOe[P]  = dirQ[P];
          padOut[P] = dataQ[P];
        end
        dataView[P] = (!selQ[P] && dirQ[P]) ? dataQ[P] : padIn[P];
      end
    end

    assign spiMisoIn[g] = selQ[BASE+ROLE_MISO] & padIn[BASE+ROLE_MISO];
    assign spiMosiIn[g] = selQ[BASE+ROLE_MOSI] & padIn[BASE+ROLE_MOSI];
    assign spiSckIn[g]  = selQ[BASE+ROLE_SCK]  & padIn[BASE+ROLE_SCK];
    assign spiSsIn[g]   = selQ[BASE+ROLE_SS] ? padIn[BASE+ROLE_SS] : 1'b1;
  end

  always_comb begin
    unique case (rdSel)
      REG_SEL:  busRdData = selQ;
      REG_DIR:  busRdData = dirQ;
      REG_DATA: busRdData = dataView;
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/spi_gpio_pinmux.sv
module spi_gpio_pinmux
  import pinmux_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWrEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic [7:0] padIn,
  output logic [7:0] padOut,
  output logic [7:0] padOe,
  input  logic [1:0] spiMaster,
  input  logic [1:0] spiMisoOut,
  input  logic [1:0] spiMosiOut,
  input  logic [1:0] spiSckOut,
  output logic [1:0] spiMisoIn,
  output logic [1:0] spiMosiIn,
  output logic [1:0] spiSckIn,
  output logic [1:0] spiSsIn,
  output logic [1:0] ssValid,
  output logic [1:0] cfgError
);
  localparam int NUM_SPI = 2;

  regStb_t    stb;
  regSel_e    rdSel;
  logic [7:0] selQ;
  logic [7:0] dirQ;

  pinmux_ctrl #(.NUM_SPI(NUM_SPI)) ctrl_i (
    .busAddr(busAddr), .busWrEn(busWrEn), .selQ(selQ), .spiMaster(spiMaster),
    .stb(stb), .rdSel(rdSel), .ssValid(ssValid), .cfgError(cfgError)
  );

  pinmux_datapath #(.NUM_SPI(NUM_SPI)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel),
    .busWrData(busWrData), .busRdData(busRdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .spiMaster(spiMaster), .spiMisoOut(spiMisoOut), .spiMosiOut(spiMosiOut),
    .spiSckOut(spiSckOut), .spiMisoIn(spiMisoIn), .spiMosiIn(spiMosiIn),
    .spiSckIn(spiSckIn), .spiSsIn(spiSsIn), .selQ(selQ), .dirQ(dirQ)
  );
endmodule

// File: rtl/spi_gpio_pinmux_chk.sv
module spi_gpio_pinmux_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] busAddr,
  input logic       busWrEn,
  input logic [7:0] busWrData,
  input logic [7:0] padOe,
  input logic [1:0] spiMaster,
  input logic [1:0] spiSsIn,
  input logic [1:0] ssValid,
  input logic [1:0] cfgError,
  input logic [7:0] selQ,
  input logic [7:0] dirQ
);
  always @(posedge clk) begin
    if (!rstN) a_r1_reset_quiet: assert (padOe == 8'h00);
  end

  a_r2_sel_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd0) |=> (selQ == $past(busWrData)));

  a_r2_addr3_inert: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd3) |=> ($stable(selQ) && $stable(dirQ)));

  a_r3_gpio_dir: assert property (@(posedge clk) disable iff (!rstN)
    !selQ[0] |-> (padOe[0] == dirQ[0]));

  a_r4_mosi_master: assert property (@(posedge clk) disable iff (!rstN)
    (selQ[1] && spiMaster[0]) |-> padOe[1]);

  a_r4_ss_input: assert property (@(posedge clk) disable iff (!rstN)
    selQ[7] |-> !padOe[7]);

  a_r6_ss_idle: assert property (@(posedge clk) disable iff (!rstN)
    !selQ[3] |-> spiSsIn[0]);

  a_r8_ss_valid: assert property (@(posedge clk) disable iff (!rstN)
    ssValid[1] == selQ[7]);

  a_r9_slave_bad: assert property (@(posedge clk) disable iff (!rstN)
    (!spiMaster[0] && !selQ[3]) |-> cfgError[0]);
endmodule

bind spi_gpio_pinmux spi_gpio_pinmux_chk chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .padOe(padOe), .spiMaster(spiMaster),
  .spiSsIn(spiSsIn), .ssValid(ssValid), .cfgError(cfgError),
  .selQ(selQ), .dirQ(dirQ)
);

// File: tb/spi_gpio_pinmux_tb_top.sv
module spi_gpio_pinmux_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [7:0] padIn = '0;
  logic [7:0] padOut, padOe;
  logic [1:0] spiMaster = '0, spiMisoOut = '0, spiMosiOut = '0, spiSckOut = '0;
  logic [1:0] spiMisoIn, spiMosiIn, spiSckIn, spiSsIn, ssValid, cfgError;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int mSel = 0, mDir = 0, mData = 0;

  always #10 clk = ~clk;

  spi_gpio_pinmux dut_i (.*);

  // behavioural reference: register contents
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSel <= 0; mDir <= 0; mData <= 0;
    end else if (busWrEn) begin
      case (busAddr)
        2'd0: mSel <= busWrData;
        2'd1: mDir <= busWrData;
        2'd2: mData <= busWrData;
        default: ;
      endcase
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bitOf(input int v, input int i);
    return (v >> i) & 1;
  endfunction

  task automatic compareAll();
    int expOe = 0, expOut = 0, expView = 0, expRd;
    for (int p = 0; p < 8; p++) begin
      int g = p / 4;
      int role = p % 4;
      int m = spiMaster[g];
      int oe, val;
      if (bitOf(mSel, p) == 1) begin
        if (role == 0) begin oe = (m == 0); val = spiMisoOut[g]; end
        else if (role == 1) begin oe = m; val = spiMosiOut[g]; end
        else if (role == 2) begin oe = m; val = spiSckOut[g]; end
        else begin oe = 0; val = 0; end
        if (oe == 0) val = 0;
      end else begin
        oe = bitOf(mDir, p);
        val = bitOf(mData, p);
      end
      expOe |= oe << p;
      expOut |= val << p;
      if (bitOf(mSel, p) == 0 && bitOf(mDir, p) == 1) expView |= bitOf(mData, p) << p;
      else expView |= int'(padIn[p]) << p;
    end
    if (!rstN) begin
      check("R1 padOe in reset", padOe, 0);
    end
    check((mSel != 0) ? "R4 padOe" : "R3 padOe", padOe, expOe);
    check((mSel != 0) ? "R5 padOut" : "R3 padOut", padOut, expOut);
    case (busAddr)
      2'd0: expRd = mSel;
      2'd1: expRd = mDir;
      2'd2: expRd = expView;
      default: expRd = 0;
    endcase
    check((busAddr == 2'd2) ? "R7 data read" : "R2 register read", busRdData, expRd);
    for (int g = 0; g < 2; g++) begin
      int b = 4 * g;
      check("R6 miso in", spiMisoIn[g], bitOf(mSel, b) & int'(padIn[b]));
      check("R6 mosi in", spiMosiIn[g], bitOf(mSel, b+1) & int'(padIn[b+1]));
      check("R6 sck in", spiSckIn[g], bitOf(mSel, b+2) & int'(padIn[b+2]));
      check("R6 ss in", spiSsIn[g], bitOf(mSel, b+3) == 1 ? int'(padIn[b+3]) : 1);
      check("R8 ssValid", ssValid[g], bitOf(mSel, b+3));
      check("R9 cfgError", cfgError[g],
            (spiMaster[g] == 0 && ((mSel >> b) & 15) != 15) ? 1 : 0);
    end
  endtask

  task automatic stepDirected(input logic [1:0] a, input logic we, input logic [7:0] d,
                              input logic [1:0] role);
    @(negedge clk);
    compareAll();
    busAddr = a; busWrEn = we; busWrData = d; spiMaster = role;
    padIn = 8'($urandom); spiMisoOut = 2'($urandom);
    spiMosiOut = 2'($urandom); spiSckOut = 2'($urandom);
  endtask

  initial begin
    // R1: reset state, every register read at its address
    for (int a = 0; a < 4; a++) stepDirected(2'(a), 1'b0, 8'h00, 2'b00);
    @(negedge clk);
    rstN = 1'b1;
    // R2 / R3: GPIO outputs and data
    stepDirected(2'd1, 1'b1, 8'hA5, 2'b00);
    stepDirected(2'd2, 1'b1, 8'h3C, 2'b00);
    stepDirected(2'd2, 1'b0, 8'h00, 2'b00);
    // R2: address 3 write leaves everything as it was
    stepDirected(2'd3, 1'b1, 8'hFF, 2'b00);
    stepDirected(2'd0, 1'b0, 8'h00, 2'b00);
    stepDirected(2'd1, 1'b0, 8'h00, 2'b00);
    // R4 / R9: master with SS as GPIO, then slave with SS missing
    stepDirected(2'd0, 1'b1, 8'h77, 2'b11);
    stepDirected(2'd2, 1'b0, 8'h00, 2'b11);
    stepDirected(2'd2, 1'b0, 8'h00, 2'b00);
    // R4 / R8: full ownership, both roles
    stepDirected(2'd0, 1'b1, 8'hFF, 2'b01);
    stepDirected(2'd1, 1'b1, 8'hFF, 2'b10);
    stepDirected(2'd2, 1'b0, 8'h00, 2'b01);
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      stepDirected(2'($urandom), ($urandom % 3) == 0, 8'($urandom),
                   ($urandom % 8) == 0 ? 2'($urandom) : spiMaster);
      if (i == 2000) begin
        @(negedge clk); rstN = 1'b0;
        stepDirected(2'd0, 1'b0, 8'h00, 2'b00);
        @(negedge clk); rstN = 1'b1;
      end
    end
    @(negedge clk);
    compareAll();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule